// File: doc/BRIEF.md
# Paged DMA Address Translation Table

This block maps the addresses that devices put on an I/O bus to physical memory addresses. It holds a flat table of 64-bit words, one per I/O page. The low two bits of each word are an access code. The rest of the word, with its page-offset bits cleared, is the physical page address. The page size is 2^`PAGE_SHIFT` bytes and the table has `DEPTH` entries. Both are parameters.

A lookup port takes an I/O address and a direction flag. One cycle later it returns a registered result:
- the page-aligned I/O address;
- the physical page address;
- a mask that covers the in-page offset bits;
- the two-bit access code;
- a fault flag that is set when the requested direction is not allowed.

An address beyond the table window does not produce an error. It returns a result that grants no access and carries an all-ones mask.

A separate entry-access port writes or reads one table word at a time. It is driven by a small state machine with two states:
- `CFG_IDLE` waits for `cfg_req` and transitions to `CFG_EXEC` when it sees one. On that transition it latches the operation and computes the index as (address − `BUS_OFFSET`) >> `PAGE_SHIFT`.
- `CFG_EXEC` performs the write or read and posts a one-cycle `cfg_done` with a status. It always transitions back to `CFG_IDLE`.

An index at or above `DEPTH` is answered with a parameter-error status, and the table is not touched. Reset clears every entry, so every page faults until software fills it.

Top module: `dma_xlate_table`

## Requirements
- R1: While `rst_n` is low, every table entry is cleared to zero. A lookup or an entry read after reset therefore sees code 0 and a zero word.
- R2: A lookup is in the window only when `lk_addr >> PAGE_SHIFT` is below `DEPTH`. No bus offset is applied on the lookup path.
- R3: For an in-window lookup, the outputs are as follows:
  - `lk_iova` is `lk_addr` with its low `PAGE_SHIFT` bits cleared.
  - `lk_phys` is the stored word with its low `PAGE_SHIFT` bits cleared.
  - `lk_mask` is 2^`PAGE_SHIFT` − 1, zero-extended to 64 bits.
- R4: For an in-window lookup, `lk_perm` equals bits [1:0] of the stored word. The codes are 0 = no access, 1 = read only, 2 = write only and 3 = read and write.
- R5: For an out-of-window lookup, `lk_iova` and `lk_phys` are zero, `lk_mask` is all ones, `lk_perm` is 0 and `lk_fault` is 1.
- R6: `lk_fault` is 1 in exactly these cases:
  - `lk_is_write` is 1 and bit 1 of the returned code is 0;
  - `lk_is_write` is 0 and bit 0 of the returned code is 0.
- R7: Each lookup result appears on the clock edge after the edge that samples `lk_req`, with `lk_valid` high for that cycle. `lk_valid` is low in a cycle that follows no request.
- R8: An entry write with an in-range index stores the full 64-bit `cfg_wdata` and reports status 0 (success). The index is (`cfg_addr` − `BUS_OFFSET`) >> `PAGE_SHIFT`, computed modulo 2^`ADDR_W`.
- R9: An entry write whose index is at or above `DEPTH` reports status 1 (parameter error) and leaves every entry unchanged. This includes addresses below `BUS_OFFSET`, which wrap to a large index.
- R10: An entry read with an in-range index returns status 0 and the stored word on `cfg_rdata`. An out-of-range read returns status 1 and a zero `cfg_rdata`.
- R11: The timing and busy behaviour of the entry-access port is as follows:
  - `cfg_done` is high for exactly one cycle, two edges after the edge that samples `cfg_req` in `CFG_IDLE`.
  - `cfg_status` and `cfg_rdata` are valid while `cfg_done` is high.
  - A request presented while the state is `CFG_EXEC` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears the table |
| lk_req | input | 1 | Lookup request strobe |
| lk_addr | input | ADDR_W | I/O bus address to translate |
| lk_is_write | input | 1 | 1 = device write access, 0 = device read access |
| lk_valid | output | 1 | Lookup result valid |
| lk_iova | output | ADDR_W | Page-aligned I/O address |
| lk_phys | output | 64 | Translated physical page address |
| lk_mask | output | 64 | In-page offset mask |
| lk_perm | output | 2 | Access code of the page |
| lk_fault | output | 1 | Requested direction not permitted |
| cfg_req | input | 1 | Entry access request strobe |
| cfg_write | input | 1 | 1 = write entry, 0 = read entry |
| cfg_addr | input | ADDR_W | Bus address that selects the entry |
| cfg_wdata | input | 64 | Entry word to store |
| cfg_done | output | 1 | Entry access complete |
| cfg_status | output | 1 | 0 = success, 1 = parameter error |
| cfg_rdata | output | 64 | Entry word read |

## Verification
The assertions assume that `lk_req` and `cfg_req` are held low while `rst_n` is low. This is needed because the checks that look one cycle back must not see a request from the reset cycle.

They also assume that a new entry request is only raised once `cfg_done` has been seen. The single exception is the deliberate overlap test, which raises a request during `CFG_EXEC` to show that it is dropped.

The stimulus drives every input on the falling clock edge. It samples results on the next falling edge, or on the one after it for the entry port. Requests are held low around both resets.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RD   = 2'd1,
        PERM_WR   = 2'd2,
        PERM_RW   = 2'd3
    } perm_e;

    typedef enum logic {
        STAT_OK    = 1'b0,
        STAT_PARAM = 1'b1
    } cfg_status_e;

    typedef enum logic {
        CFG_IDLE = 1'b0,
        CFG_EXEC = 1'b1
    } cfg_state_e;

    localparam int unsigned ENTRY_W = 64;
endpackage

// File: rtl/xlt_entry_store.sv
module xlt_entry_store
    import xlt_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [IDX_W-1:0]   rd_a_idx,
    output logic [ENTRY_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]   rd_b_idx,
    output logic [ENTRY_W-1:0] rd_b_data
);
    logic [ENTRY_W-1:0] mem_q [DEPTH];

    // One register word per entry, each cleared by reset.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                mem_q[g] <= wr_data;
            end
        end
    end

    // Guarded reads: an index past the table (possible for a
    // non-power-of-two depth) returns zero.
    always_comb begin
        rd_a_data = (32'(rd_a_idx) < DEPTH) ? mem_q[rd_a_idx] : '0;
        rd_b_data = (32'(rd_b_idx) < DEPTH) ? mem_q[rd_b_idx] : '0;
    end

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(wr_idx) < DEPTH)) else $error("write index past table"); // R9

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(wr_idx)] == $past(wr_data))) else $error("write lost"); // R8
endmodule

// File: rtl/xlt_lookup.sv
module xlt_lookup
    import xlt_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned DEPTH      = 16,
    parameter int unsigned IDX_W      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               is_write,
    output logic [IDX_W-1:0]   tbl_idx,
    input  logic [ENTRY_W-1:0] entry,
    output logic               valid,
    output logic [ADDR_W-1:0]  iova,
    output logic [ENTRY_W-1:0] phys,
    output logic [ENTRY_W-1:0] mask,
    output perm_e              perm,
    output logic               fault
);
    localparam int unsigned PN_W = ADDR_W - PAGE_SHIFT;
    localparam logic [ENTRY_W-1:0] E_OFFS = (64'd1 << PAGE_SHIFT) - 64'd1;
    localparam logic [ADDR_W-1:0]  A_OFFS = ADDR_W'(E_OFFS);

    logic [PN_W-1:0] page_num;
    logic            hit;
    perm_e           perm_c;
    logic            allowed;

    always_comb begin
        page_num = addr[ADDR_W-1:PAGE_SHIFT];
        hit      = (64'(page_num) < 64'(DEPTH));
        tbl_idx  = page_num[IDX_W-1:0];
        perm_c   = perm_e'(entry[1:0]);
        allowed  = is_write ? entry[1] : entry[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            iova  <= '0;
            phys  <= '0;
            mask  <= '1;
            perm  <= PERM_NONE;
            fault <= 1'b0;
        end else begin
            valid <= req;
            if (req) begin
                if (hit) begin
                    iova  <= addr & ~A_OFFS;
                    phys  <= entry & ~E_OFFS;
                    mask  <= E_OFFS;
                    perm  <= perm_c;
                    fault <= ~allowed;
                end else begin
                    iova  <= '0;
                    phys  <= '0;
                    mask  <= '1;
                    perm  <= PERM_NONE;
                    fault <= 1'b1;
                end
            end
        end
    end

    AST_REQ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> valid) else $error("missing result"); // R7
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !valid) else $error("spurious result"); // R7
    AST_ALIGNED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (iova[PAGE_SHIFT-1:0] == '0 && phys[PAGE_SHIFT-1:0] == '0)) else $error("unaligned"); // R3
    AST_MISS_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !hit) |=> (mask == '1 && perm == PERM_NONE && fault && phys == '0)) else $error("miss leaked"); // R5
    AST_FULL_PERM_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && perm == PERM_RW) |-> !fault) else $error("rw faulted"); // R6
endmodule

// File: rtl/xlt_cfg_port.sv
module xlt_cfg_port
    import xlt_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned DEPTH      = 16,
    parameter int unsigned IDX_W      = 4,
    parameter logic [63:0] BUS_OFFSET = 64'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               write,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [ENTRY_W-1:0] wdata,
    output logic [IDX_W-1:0]   rd_idx,
    input  logic [ENTRY_W-1:0] rd_entry,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [ENTRY_W-1:0] wr_data,
    output logic               done,
    output cfg_status_e        status,
    output logic [ENTRY_W-1:0] rdata
);
    localparam int unsigned PN_W = ADDR_W - PAGE_SHIFT;

    cfg_state_e         state_q, state_d;
    logic [ADDR_W-1:0]  rel_addr;
    logic [PN_W-1:0]    rel_pn;
    logic               in_range;
    logic [IDX_W-1:0]   idx_q;
    logic               ok_q;
    logic               wr_q;
    logic [ENTRY_W-1:0] wdata_q;

    always_comb begin
        rel_addr = addr - ADDR_W'(BUS_OFFSET);
        rel_pn   = rel_addr[ADDR_W-1:PAGE_SHIFT];
        in_range = (64'(rel_pn) < 64'(DEPTH));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_IDLE: if (req) state_d = CFG_EXEC;
            CFG_EXEC: state_d = CFG_IDLE;
            default:  state_d = CFG_IDLE;
        endcase
    end

    // State register and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CFG_IDLE;
            idx_q   <= '0;
            ok_q    <= 1'b0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == CFG_IDLE && req) begin
                idx_q   <= rel_pn[IDX_W-1:0];
                ok_q    <= in_range;
                wr_q    <= write;
                wdata_q <= wdata;
            end
        end
    end

    always_comb begin
        rd_idx  = idx_q;
        wr_idx  = idx_q;
        wr_data = wdata_q;
        wr_en   = (state_q == CFG_EXEC) && wr_q && ok_q;
    end

    // Registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            status <= STAT_OK;
            rdata  <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                CFG_IDLE: ;
                CFG_EXEC: begin
                    done   <= 1'b1;
                    status <= ok_q ? STAT_OK : STAT_PARAM;
                    rdata  <= (!wr_q && ok_q) ? rd_entry : '0;
                end
                default: ;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done held"); // R11
    AST_REQ_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CFG_IDLE && req) |=> ##1 done) else $error("no response"); // R11
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == STAT_PARAM) |-> (rdata == '0)) else $error("error with data"); // R10
endmodule

// File: rtl/dma_xlate_table.sv
module dma_xlate_table
    import xlt_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned DEPTH      = 16,
    parameter logic [63:0] BUS_OFFSET = 64'h0001_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_is_write,
    output logic              lk_valid,
    output logic [ADDR_W-1:0] lk_iova,
    output logic [63:0]       lk_phys,
    output logic [63:0]       lk_mask,
    output logic [1:0]        lk_perm,
    output logic              lk_fault,
    input  logic              cfg_req,
    input  logic              cfg_write,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [63:0]       cfg_wdata,
    output logic              cfg_done,
    output logic              cfg_status,
    output logic [63:0]       cfg_rdata
);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDX_W-1:0]   lk_idx, cfg_rd_idx, wr_idx;
    logic [ENTRY_W-1:0] lk_entry, cfg_entry, wr_data;
    logic               wr_en;
    perm_e              perm_w;
    cfg_status_e        status_w;

    xlt_entry_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_a_idx(lk_idx), .rd_a_data(lk_entry),
        .rd_b_idx(cfg_rd_idx), .rd_b_data(cfg_entry)
    );

    xlt_lookup #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_lookup (
        .clk(clk), .rst_n(rst_n),
        .req(lk_req), .addr(lk_addr), .is_write(lk_is_write),
        .tbl_idx(lk_idx), .entry(lk_entry),
        .valid(lk_valid), .iova(lk_iova), .phys(lk_phys), .mask(lk_mask),
        .perm(perm_w), .fault(lk_fault)
    );

    xlt_cfg_port #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .DEPTH(DEPTH),
                   .IDX_W(IDX_W), .BUS_OFFSET(BUS_OFFSET)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .req(cfg_req), .write(cfg_write), .addr(cfg_addr), .wdata(cfg_wdata),
        .rd_idx(cfg_rd_idx), .rd_entry(cfg_entry),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .done(cfg_done), .status(status_w), .rdata(cfg_rdata)
    );

    assign lk_perm    = perm_w;
    assign cfg_status = status_w;
endmodule

// File: tb/dma_xlate_table_test.sv
module dma_xlate_table_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0, lk_is_write = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_valid, lk_fault;
    logic [31:0] lk_iova;
    logic [63:0] lk_phys, lk_mask;
    logic [1:0]  lk_perm;
    logic        cfg_req = 1'b0, cfg_write = 1'b0;
    logic [31:0] cfg_addr = '0;
    logic [63:0] cfg_wdata = '0;
    logic        cfg_done, cfg_status;
    logic [63:0] cfg_rdata;

    int nchk = 0, nfail = 0;
    bit finished = 0;

    localparam logic [31:0] OFS = 32'h0001_0000;
    localparam logic [63:0] PMASK = 64'hFFF;

    always #5 clk = ~clk;

    dma_xlate_table uut (.*);

    task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic lookup(logic [31:0] a, logic w);
        @(negedge clk);
        lk_req = 1'b1; lk_addr = a; lk_is_write = w;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic cfg_op(logic w, logic [31:0] a, logic [63:0] d,
                          output logic st, output logic [63:0] rd);
        @(negedge clk);
        cfg_req = 1'b1; cfg_write = w; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_req = 1'b0;
        chk("R11 done early", cfg_done, 0);
        @(negedge clk);
        chk("R11 done", cfg_done, 1);
        st = cfg_status; rd = cfg_rdata;
        @(negedge clk);
        chk("R11 done pulse", cfg_done, 0);
    endtask

    function automatic logic [31:0] eaddr(int idx);
        return OFS + 32'(idx) * 32'h1000;
    endfunction

    task automatic t_reset();
        logic st; logic [63:0] rd;
        lookup(32'h0000_3004, 1'b0);
        chk("R1 valid", lk_valid, 1);
        chk("R1 perm", lk_perm, 0);
        chk("R1 phys", lk_phys, 0);
        chk("R1 fault", lk_fault, 1);
        chk("R3 iova", lk_iova, 32'h3000);
        cfg_op(1'b0, eaddr(5) + 32'h10, '0, st, rd);
        chk("R1 read status", st, 0);
        chk("R1 read data", rd, 0);
    endtask

    task automatic t_write_lookup();
        logic st; logic [63:0] rd;
        cfg_op(1'b1, eaddr(3) + 32'h44, 64'h0000_00AB_CDEF_5003, st, rd);
        chk("R8 status", st, 0);
        lookup(32'h0000_3ABC, 1'b0);
        chk("R3 iova", lk_iova, 32'h3000);
        chk("R3 phys", lk_phys, 64'h0000_00AB_CDEF_5000);
        chk("R3 mask", lk_mask, PMASK);
        chk("R4 perm rw", lk_perm, 3);
        chk("R6 rw read", lk_fault, 0);
        lookup(32'h0000_3000, 1'b1);
        chk("R6 rw write", lk_fault, 0);
        cfg_op(1'b0, eaddr(3), '0, st, rd);
        chk("R10 status", st, 0);
        chk("R10 data", rd, 64'h0000_00AB_CDEF_5003);
    endtask

    task automatic t_perm();
        logic st; logic [63:0] rd;
        cfg_op(1'b1, eaddr(7), 64'h0000_0000_1234_0001, st, rd);
        cfg_op(1'b1, eaddr(8), 64'h0000_0000_5678_0002, st, rd);
        lookup(32'h0000_7010, 1'b0);
        chk("R4 ro perm", lk_perm, 1);
        chk("R6 ro read", lk_fault, 0);
        lookup(32'h0000_7010, 1'b1);
        chk("R6 ro write", lk_fault, 1);
        lookup(32'h0000_8FFF, 1'b0);
        chk("R4 wo perm", lk_perm, 2);
        chk("R6 wo read", lk_fault, 1);
        chk("R3 wo phys", lk_phys, 64'h5678_0000);
        lookup(32'h0000_8FFF, 1'b1);
        chk("R6 wo write", lk_fault, 0);
    endtask

    task automatic t_window();
        lookup(32'h0000_F123, 1'b0);
        chk("R2 last page mask", lk_mask, PMASK);
        chk("R2 last page iova", lk_iova, 32'h0000_F000);
        lookup(32'h0001_0123, 1'b1);
        chk("R2 first miss valid", lk_valid, 1);
        chk("R5 iova", lk_iova, 0);
        chk("R5 phys", lk_phys, 0);
        chk("R5 mask", lk_mask, '1);
        chk("R5 perm", lk_perm, 0);
        chk("R5 fault", lk_fault, 1);
        lookup(32'hFFFF_F000, 1'b0);
        chk("R5 high mask", lk_mask, '1);
        @(negedge clk);
        chk("R7 idle valid", lk_valid, 0);
    endtask

    task automatic t_cfg_reject();
        logic st; logic [63:0] rd;
        cfg_op(1'b1, eaddr(16), 64'hDEAD_0003, st, rd);
        chk("R9 past end status", st, 1);
        cfg_op(1'b1, OFS - 32'h1000, 64'hBEEF_0003, st, rd);
        chk("R9 below offset status", st, 1);
        for (int i = 0; i < 16; i++) begin
            cfg_op(1'b0, eaddr(i), '0, st, rd);
            chk("R9 table unchanged", rd,
                (i == 3) ? 64'h0000_00AB_CDEF_5003 :
                (i == 7) ? 64'h1234_0001 :
                (i == 8) ? 64'h5678_0002 : 64'h0);
        end
        cfg_op(1'b0, eaddr(20), '0, st, rd);
        chk("R10 oor status", st, 1);
        chk("R10 oor data", rd, 0);
    endtask

    task automatic t_busy();
        logic st; logic [63:0] rd;
        @(negedge clk);
        cfg_req = 1'b1; cfg_write = 1'b1; cfg_addr = eaddr(9); cfg_wdata = 64'hA000_0003;
        @(negedge clk);
        cfg_addr = eaddr(10); cfg_wdata = 64'hB000_0003;
        @(negedge clk);
        cfg_req = 1'b0;
        chk("R11 busy done", cfg_done, 1);
        @(negedge clk);
        cfg_op(1'b0, eaddr(10), '0, st, rd);
        chk("R11 busy ignored", rd, 0);
        cfg_op(1'b0, eaddr(9), '0, st, rd);
        chk("R8 first kept", rd, 64'hA000_0003);
    endtask

    task automatic t_reset_again();
        logic st; logic [63:0] rd;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        lookup(32'h0000_3000, 1'b0);
        chk("R1 cleared perm", lk_perm, 0);
        chk("R1 cleared fault", lk_fault, 1);
        cfg_op(1'b0, eaddr(9), '0, st, rd);
        chk("R1 cleared word", rd, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset valid", lk_valid, 0);
        chk("R11 reset done", cfg_done, 0);
        t_reset();
        t_write_lookup();
        t_perm();
        t_window();
        t_cfg_reject();
        t_busy();
        t_reset_again();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule